// File: doc/BRIEF.md
# Interlace-Aware Scan Line Sequencer

This block produces the scan line number inside the current character row and the odd/even field flag for a character-cell raster display. Timing comes from outside: one strobe marks the end of each horizontal line and another marks the start of each vertical field. The block counts lines within a row, raises a strobe on the last line of the row, and then wraps the count. The character generator and the cursor compare logic use the row address.

A 2-bit mode setting selects the scan type. Progressive scanning refreshes every line once per field. Repeat-interlace draws the same lines in both fields of a two-field frame. Split-interlace draws even lines of each character in the even field and odd lines in the odd field. It does this by stepping the row address by two from a starting parity equal to the field flag. The mode and the last-line setting are captured only at a field start, so a software write in the middle of a field never splits a frame.

Top module: `scanline_seq`

## Requirements
- R1: After synchronous active-low reset, row_addr is 0 and field_odd is 0. The captured mode is progressive and the captured last line is 0, so row_end is 1.
- R2: Mode codes 2'b00 and 2'b10 are progressive. field_odd stays 0 across field starts, and row_addr counts 0,1,...,last_line in steps of one.
- R3: Mode code 2'b01 is repeat-interlace. field_odd inverts at every field start, and both fields show the same sequence 0,1,...,last_line.
- R4: Mode code 2'b11 is split-interlace. row_addr starts at the field_odd value and steps by two, so bit 0 of row_addr always equals field_odd.
- R5: row_end is high during the last line of the row. In progressive and repeat-interlace modes this is the line where row_addr equals the captured last line. In split-interlace mode it is last_line in the odd field and last_line-1 in the even field, with last_line odd.
- R6: An end-of-line pulse while row_end is high wraps row_addr to the row base. The base is field_odd in split-interlace mode and 0 otherwise.
- R7: The mode and last_line inputs take effect only at a field start pulse. Changes between field starts do not alter the row sequence or the field flag.
- R8: When a field start and an end-of-line arrive in the same cycle, the field start wins. The row address goes to the new base, and the field flag updates.
- R9: A field start in the middle of a row resets row_addr to the base for the new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| field_start | input | 1 | One-cycle pulse at the start of each vertical field |
| mode_cfg | input | 2 | Scan mode: bit 0 enables interlace, bit 1 with bit 0 selects split-interlace |
| last_line | input | 5 | Scan lines per row minus one |
| row_addr | output | 5 | Scan line number within the current character row |
| row_end | output | 1 | High during the last scan line of a row |
| field_odd | output | 1 | Field flag, 1 in the odd field |

## Verification
A wrong field flag shows at once in split-interlace mode as a row address of the wrong parity. In repeat-interlace mode it shows at the next field start as a missing inversion. A wrong count or step shows on the next end-of-line pulse as a wrong row_addr. A wrong end-of-row comparison shows within one row as a strobe on the wrong line or a count that runs past last_line. A configuration capture that leaks between field starts shows on the first line after the stray write, as a changed step or a changed end line.

// File: rtl/scanline_pkg.sv
// Shared types and decode helpers for the scan line sequencer.
package scanline_pkg;

    // Scan mode encodings as they appear on the mode input.
    typedef enum logic [1:0] {
        SCAN_PROG     = 2'b00,
        SCAN_REPEAT   = 2'b01,
        SCAN_PROG_ALT = 2'b10,
        SCAN_SPLIT    = 2'b11
    } scan_mode_e;

    // True for either two-field mode.
    function automatic logic mode_interlaced(input logic [1:0] m);
        return m[0];
    endfunction

    // True when alternate lines go to alternate fields.
    function automatic logic mode_split(input logic [1:0] m);
        return m[0] & m[1];
    endfunction

endpackage

// File: rtl/scan_cfg_latch.sv
// Captures the mode and last-line settings at each field start.
// Assumes field_start is a single-cycle pulse from the vertical timing.
module scan_cfg_latch
    import scanline_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic [1:0]       mode_in,
    input  logic [ROW_W-1:0] last_in,
    output scan_mode_e       mode_q,
    output logic [ROW_W-1:0] last_q
);

    // Register the settings only on a field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SCAN_PROG;
            last_q <= '0;
        end else if (field_start) begin
            mode_q <= scan_mode_e'(mode_in);
            last_q <= last_in;
        end
    end

    // R7: settings hold between field starts.
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(mode_q) && $stable(last_q)));

endmodule

// File: rtl/scan_field_track.sv
// Keeps the odd/even field flag. It inverts at each field start when the
// newly captured mode is interlaced, and it is cleared otherwise.
module scan_field_track
    import scanline_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_start,
    input  logic [1:0] mode_in,
    input  scan_mode_e mode_q,
    output logic       field_nxt,
    output logic       field_q
);

    // Next flag value, using the mode captured at this same boundary.
    always_comb begin
        field_nxt = mode_interlaced(mode_in) ? ~field_q : 1'b0;
    end

    // Flag register, updated only at field start.
    always_ff @(posedge clk) begin
        if (!rst_n)           field_q <= 1'b0;
        else if (field_start) field_q <= field_nxt;
    end

    // R2: the flag is zero while a progressive mode is captured.
    assert_field_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_interlaced(mode_q) |-> !field_q);

    // R3: the flag moves only at a field start.
    assert_field_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(field_q));

endmodule

// File: rtl/scan_row_count.sv
// Counts scan lines within a character row. It steps by one or two,
// wraps to a base at the row end, and reloads at a restart.
// Assumes the base value is 0 or 1.
module scan_row_count #(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             restart_base,
    input  logic             advance,
    input  logic             step_two,
    input  logic             wrap_base,
    input  logic [ROW_W-1:0] end_line,
    output logic [ROW_W-1:0] row_q,
    output logic             at_end
);

    localparam logic [ROW_W-1:0] STEP1 = ROW_W'(1);
    localparam logic [ROW_W-1:0] STEP2 = ROW_W'(2);

    logic [ROW_W-1:0] row_inc;

    // End detect and increment value.
    always_comb begin
        at_end  = (row_q >= end_line);
        row_inc = row_q + (step_two ? STEP2 : STEP1);
    end

    // Row address register: restart wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_q <= '0;
        else if (restart) row_q <= {{(ROW_W-1){1'b0}}, restart_base};
        else if (advance) row_q <= at_end ? {{(ROW_W-1){1'b0}}, wrap_base} : row_inc;
    end

    // R6: a line end at the row end lands on a base of 0 or 1.
    assert_wrap_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && at_end) |=> (row_q <= STEP1));

    // R4: a double step keeps the parity of the address.
    assert_step_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && !at_end && step_two) |=> (row_q[0] == $past(row_q[0])));

    // R8: a restart overrides any advance in the same cycle.
    assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (row_q <= STEP1));

endmodule

// File: rtl/scanline_seq.sv
// Top of the scan line sequencer. It ties together the settings capture,
// the field flag and the row counter, and it selects the end line of the
// row for the current mode and field.
// Assumes last_line is odd whenever the split-interlace mode is captured.
module scanline_seq
    import scanline_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic             field_start,
    input  logic [1:0]       mode_cfg,
    input  logic [ROW_W-1:0] last_line,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_end,
    output logic             field_odd
);

    scan_mode_e       mode_q;
    logic [ROW_W-1:0] last_q;
    logic             field_nxt;
    logic             split_q;
    logic             restart_base;
    logic [ROW_W-1:0] end_sel;

    scan_cfg_latch #(.ROW_W(ROW_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .mode_in(mode_cfg), .last_in(last_line),
        .mode_q(mode_q), .last_q(last_q)
    );

    scan_field_track u_field (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .mode_in(mode_cfg), .mode_q(mode_q),
        .field_nxt(field_nxt), .field_q(field_odd)
    );

    // End line: the even field of split-interlace stops one line early.
    always_comb begin
        split_q      = mode_split(mode_q);
        restart_base = mode_split(mode_cfg) & field_nxt;
        end_sel      = (split_q && !field_odd) ? {last_q[ROW_W-1:1], 1'b0} : last_q;
    end

    scan_row_count #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n),
        .restart(field_start), .restart_base(restart_base),
        .advance(line_end), .step_two(split_q),
        .wrap_base(split_q & field_odd), .end_line(end_sel),
        .row_q(row_addr), .at_end(row_end)
    );

    // R4: in split-interlace, the address parity follows the field.
    assert_split_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        split_q |-> (row_addr[0] == field_odd));

    // R9: the address after a field start is 0 or 1.
    assert_field_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (row_addr <= ROW_W'(1)));

endmodule

// File: tb/tb_scanline_seq.sv
module tb_scanline_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_end = 1'b0;
    logic       field_start = 1'b0;
    logic [1:0] mode_cfg = 2'b00;
    logic [4:0] last_line = 5'd0;
    logic [4:0] row_addr;
    logic       row_end;
    logic       field_odd;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    scanline_seq dut (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .field_start(field_start),
        .mode_cfg(mode_cfg), .last_line(last_line),
        .row_addr(row_addr), .row_end(row_end), .field_odd(field_odd)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_line();
        @(negedge clk) line_end = 1'b1;
        @(negedge clk) line_end = 1'b0;
    endtask

    task automatic new_field(input logic [1:0] m, input logic [4:0] l);
        @(negedge clk) begin mode_cfg = m; last_line = l; field_start = 1'b1; end
        @(negedge clk) field_start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "row_addr", int'(row_addr), 0);
        check("R1", "field_odd", int'(field_odd), 0);
        check("R1", "row_end", int'(row_end), 1);
    endtask

    task automatic t_progressive();
        new_field(2'b10, 5'd3);
        check("R2", "field_odd", int'(field_odd), 0);
        for (int i = 0; i < 6; i++) begin
            check("R2", "row_addr", int'(row_addr), i % 4);
            check("R5", "row_end", int'(row_end), int'((i % 4) == 3));
            pulse_line();
        end
        new_field(2'b00, 5'd3);
        check("R2", "field_odd after 2nd start", int'(field_odd), 0);
    endtask

    task automatic t_repeat();
        new_field(2'b01, 5'd2);
        check("R3", "field_odd first", int'(field_odd), 1);
        for (int i = 0; i < 4; i++) begin
            check("R3", "row_addr odd field", int'(row_addr), i % 3);
            check("R5", "row_end", int'(row_end), int'((i % 3) == 2));
            pulse_line();
        end
        new_field(2'b01, 5'd2);
        check("R3", "field_odd second", int'(field_odd), 0);
        for (int i = 0; i < 3; i++) begin
            check("R3", "row_addr even field", int'(row_addr), i);
            pulse_line();
        end
        check("R6", "wrap to 0", int'(row_addr), 0);
    endtask

    task automatic t_split();
        new_field(2'b11, 5'd7);
        check("R4", "field_odd", int'(field_odd), 1);
        for (int i = 0; i < 5; i++) begin
            check("R4", "row_addr odd field", int'(row_addr), 1 + 2 * (i % 4));
            check("R5", "row_end odd field", int'(row_end), int'((i % 4) == 3));
            pulse_line();
        end
        new_field(2'b11, 5'd7);
        check("R4", "field_odd", int'(field_odd), 0);
        for (int i = 0; i < 4; i++) begin
            check("R4", "row_addr even field", int'(row_addr), 2 * i);
            check("R5", "row_end even field", int'(row_end), int'(i == 3));
            pulse_line();
        end
        check("R6", "wrap to even base", int'(row_addr), 0);
    endtask

    task automatic t_capture();
        @(negedge clk) begin mode_cfg = 2'b00; last_line = 5'd1; end
        for (int i = 0; i < 4; i++) begin
            check("R7", "row_addr keeps old step", int'(row_addr), 2 * i);
            check("R7", "row_end keeps old end", int'(row_end), int'(i == 3));
            pulse_line();
        end
        check("R7", "field_odd unchanged", int'(field_odd), 0);
        new_field(2'b00, 5'd1);
        check("R7", "row after capture", int'(row_addr), 0);
        pulse_line();
        check("R7", "new step of one", int'(row_addr), 1);
        check("R7", "new end line", int'(row_end), 1);
    endtask

    task automatic t_priority();
        new_field(2'b01, 5'd3);
        check("R3", "field_odd", int'(field_odd), 1);
        pulse_line();
        pulse_line();
        check("R9", "mid-row before restart", int'(row_addr), 2);
        @(negedge clk) begin line_end = 1'b1; field_start = 1'b1; end
        @(negedge clk) begin line_end = 1'b0; field_start = 1'b0; end
        check("R8", "row_addr after joint pulse", int'(row_addr), 0);
        check("R8", "field_odd after joint pulse", int'(field_odd), 0);
        pulse_line();
        check("R9", "count resumes", int'(row_addr), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_progressive();
        t_repeat();
        t_split();
        t_capture();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule